// File: doc/BRIEF.md
# Two-phase count PWM generator

This block drives a single pulse-width-modulated output. The high and low phases are set by two separate count registers, an active count and an idle count, instead of by one period value and one compare value. The period is therefore the sum of the two counts. A programmable pre-divider sets the base rate of the counter. It divides whichever of two external clock-enable strobes is selected, one fast and one slow.

Software programs the block through a small write port. Select 0 writes the control word, select 1 writes the active count, select 2 writes the idle count, and select 3 stores nothing. Control word fields: bit 0 turns the generator on, bit 1 picks the slow strobe when set and the fast strobe when clear, bit 2 inverts the output, and bits 6:3 hold the pre-divider value n, which divides the selected strobe by n+1. New counts are taken up only when a period begins. Turning the generator off clears its counters, so the next start begins with a fresh active phase.

Top module: `onoff_pwm`

## Requirements
- R1: After reset the output is low and all registers are zero, so the generator is off with no inversion.
- R2: While control bit 0 is clear, the output holds the inactive level, which equals control bit 2.
- R3: Control bit 1 clear makes `ce_fast` the timebase strobe, and set makes `ce_slow` the timebase strobe. The unselected strobe has no effect.
- R4: With pre-divider field n in control bits 6:3, one counter tick occurs for every n+1 selected strobes. If n is lowered below the current pre-divider count, the next strobe produces a tick.
- R5: Each period lasts active+idle ticks. The output is active for the first `active` ticks and inactive for the remaining `idle` ticks. The output is high when the generator is on, bit 2 is clear and the phase is active.
- R6: Control bit 2 set inverts the output in every state, which gives active-low operation.
- R7: Count values written while the generator runs take effect only at the start of the next period.
- R8: An active count of 0 keeps the output inactive for the whole time the generator runs.
- R9: An idle count of 0 with a nonzero active count keeps the output active for the whole time the generator runs.
- R10: Turning the generator off clears the pre-divider and the phase position and loads the current count values. The output becomes active in the first cycle after the generator is turned back on, provided the active count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 active count, 2 idle count, 3 none |
| wr_data | input | CNT_W | Write data; control uses bits 6:0 |
| ce_fast | input | 1 | Fast timebase strobe |
| ce_slow | input | 1 | Slow timebase strobe |
| pwm_out | output | 1 | PWM output, a function of registered state only |

## Verification
The bench builds the block with CNT_W set to 8. This keeps count values small, so complete periods, and the wrap of the phase position at the sum of two counts, occur within a few dozen cycles. The fast strobe fires every cycle and the slow strobe fires every fifth cycle, so the effect of clock selection shows up within one short window. Pre-divider values of 0 and 3 test both the undivided path and a divided path.

// File: rtl/onoff_pwm_pkg.sv
package onoff_pwm_pkg;
  localparam int CFG_W = 7;
  localparam int PDIV_W = 4;

  typedef struct packed {
    logic [PDIV_W-1:0] pdiv;
    logic              inv;
    logic              slow;
    logic              en;
  } ctl_t;

  // tick when the pre-divider count has reached (or passed) the field value
  function automatic logic pre_hit(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

  // last tick of a period: position+1 reaches active+idle
  function automatic logic period_last(input int unsigned pos, input int unsigned act,
                                       input int unsigned idle);
    return (pos + 1) >= (act + idle);
  endfunction
endpackage

// File: rtl/onoff_pwm_regs.sv
module onoff_pwm_regs
  import onoff_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output ctl_t             ctl,
  output logic [CNT_W-1:0] act_cnt,
  output logic [CNT_W-1:0] idle_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl      <= '0;
      act_cnt  <= '0;
      idle_cnt <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0:    ctl      <= ctl_t'(wr_data[CFG_W-1:0]);
        2'd1:    act_cnt  <= wr_data;
        2'd2:    idle_cnt <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/onoff_pwm_prescale.sv
module onoff_pwm_prescale
  import onoff_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              strobe,
  input  logic [PDIV_W-1:0] pdiv,
  output logic              tick
);
  logic [PDIV_W-1:0] pre_q;
  logic              hit;

  assign hit  = pre_hit(int'(pre_q), int'(pdiv));
  assign tick = en && strobe && hit;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) pre_q <= '0;
    else if (strobe)   pre_q <= hit ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/onoff_pwm_phase.sv
module onoff_pwm_phase
  import onoff_pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int POS_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] act_cnt,
  input  logic [CNT_W-1:0] idle_cnt,
  output logic [POS_W-1:0] pos,
  output logic [CNT_W-1:0] act_l,
  output logic             period_end,
  output logic             active
);
  logic [CNT_W-1:0] idle_l;

  assign period_end = tick && period_last(int'(pos), int'(act_l), int'(idle_l));
  assign active     = en && (pos < POS_W'(act_l));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      act_l  <= '0;
      idle_l <= '0;
    end else if (!en || period_end) begin
      pos    <= '0;
      act_l  <= act_cnt;
      idle_l <= idle_cnt;
    end else if (tick) begin
      pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/onoff_pwm.sv
module onoff_pwm
  import onoff_pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int POS_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ce_fast,
  input  logic             ce_slow,
  output logic             pwm_out
);
  ctl_t             ctl;
  logic [CNT_W-1:0] act_cnt, idle_cnt, act_l;
  logic [POS_W-1:0] pos;
  logic             tsel, tick, period_end, active;

  onoff_pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctl(ctl), .act_cnt(act_cnt), .idle_cnt(idle_cnt)
  );

  assign tsel = ctl.slow ? ce_slow : ce_fast;

  onoff_pwm_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .en(ctl.en), .strobe(tsel), .pdiv(ctl.pdiv), .tick(tick)
  );

  onoff_pwm_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(ctl.en), .tick(tick), .act_cnt(act_cnt),
    .idle_cnt(idle_cnt), .pos(pos), .act_l(act_l), .period_end(period_end),
    .active(active)
  );

  assign pwm_out = active ^ ctl.inv;
endmodule

// File: rtl/onoff_pwm_chk.sv
module onoff_pwm_chk #(
  parameter int CNT_W = 16,
  localparam int POS_W = CNT_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             inv,
  input logic             slow,
  input logic             ce_fast,
  input logic             ce_slow,
  input logic             tick,
  input logic             period_end,
  input logic [POS_W-1:0] pos,
  input logic [CNT_W-1:0] act_l,
  input logic             pwm_out
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> pwm_out == inv); // R2
  AST_TICK_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (slow ? ce_slow : ce_fast)); // R3
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(pos)); // R5
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_end) |=> $stable(act_l)); // R7
  AST_ZERO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_l == '0) |-> pwm_out == inv); // R8
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pos == '0); // R10
endmodule

bind onoff_pwm onoff_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl.en), .inv(ctl.inv), .slow(ctl.slow),
  .ce_fast(ce_fast), .ce_slow(ce_slow), .tick(tick), .period_end(period_end),
  .pos(pos), .act_l(act_l), .pwm_out(pwm_out)
);

// File: tb/sim_onoff_pwm.sv
module sim_onoff_pwm;
  localparam int CW = 8;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0, wr_en = 0, ce_fast = 1, ce_slow = 0;
  logic [1:0] wr_sel = 0;
  logic [CW-1:0] wr_data = 0;
  logic pwm_out;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";

  onoff_pwm #(.CNT_W(CW)) u0 (.*);

  always #(TCLK/2) clk = ~clk;

  // strobes: fast every cycle, slow every fifth cycle
  always @(negedge clk) begin
    cyc <= cyc + 1;
    ce_slow <= ((cyc + 1) % 5 == 0);
  end

  // behavioural reference model
  int m_cfg = 0, m_on = 0, m_off = 0, pre = 0, pos = 0, onl = 0, offl = 0;
  bit exp_out;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_on = 0; m_off = 0; pre = 0; pos = 0; onl = 0; offl = 0;
    end else begin
      bit en, ts, tk;
      int pd;
      en = m_cfg[0];
      pd = (m_cfg >> 3) & 15;
      ts = m_cfg[1] ? ce_slow : ce_fast;
      tk = en && ts && (pre >= pd);
      if (!en) begin
        pre = 0; pos = 0; onl = m_on; offl = m_off;
      end else begin
        if (ts) pre = (pre >= pd) ? 0 : pre + 1;
        if (tk) begin
          if (pos + 1 >= onl + offl) begin pos = 0; onl = m_on; offl = m_off; end
          else pos++;
        end
      end
      if (wr_en) begin
        if (wr_sel == 0) m_cfg = wr_data & 8'h7f;
        else if (wr_sel == 1) m_on = wr_data;
        else if (wr_sel == 2) m_off = wr_data;
      end
    end
  end
  assign exp_out = (m_cfg[0] && pos < onl) ^ m_cfg[2];

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pwm_out=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s value=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) check(tag, pwm_out, exp_out);

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(sel); wr_data = CW'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  // count active cycles over n negedges (first sample right after the write returns)
  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) hi++;
      if (i < n - 1) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    check("R1", pwm_out, 1'b0);
    rst_n = 1;
    idle(2);
    check("R1", pwm_out, 1'b0);

    tag = "R5";
    wr(1, 3); wr(2, 5);
    wr(0, 7'h01);
    count_high(80, hi);
    check_int("R5", hi, 30);

    tag = "R4";
    wr(0, 7'h00);
    wr(0, (3 << 3) | 1);
    count_high(64, hi);
    check_int("R4", hi, 24);

    tag = "R3";
    wr(0, 7'h00);
    wr(0, 7'h03);
    count_high(10, hi);
    check_int("R3", hi, 10);
    idle(60);

    tag = "R2";
    wr(0, 7'h04);
    check("R2", pwm_out, 1'b1);
    idle(5);
    check("R2", pwm_out, 1'b1);

    tag = "R6";
    wr(0, 7'h05);
    check("R6", pwm_out, 1'b0);
    idle(30);

    tag = "R7";
    wr(0, 7'h01);
    idle(2);
    wr(1, 6); wr(2, 2);
    idle(40);

    tag = "R8";
    wr(0, 7'h00);
    wr(1, 0); wr(2, 4);
    wr(0, 7'h01);
    count_high(20, hi);
    check_int("R8", hi, 0);

    tag = "R9";
    wr(0, 7'h00);
    wr(1, 4); wr(2, 0);
    wr(0, 7'h01);
    count_high(20, hi);
    check_int("R9", hi, 20);

    tag = "R10";
    wr(2, 6);
    idle(20);
    wr(0, 7'h00);
    check("R10", pwm_out, 1'b0);
    wr(0, 7'h01);
    check("R10", pwm_out, 1'b1);
    idle(30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(TCLK * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule